// File: doc/BRIEF.md
# Legacy Hole Address Decoder

This block steers every CPU bus access of a small PC-style system to exactly one target: main RAM, the video frame buffer, the boot firmware ROM, the expansion-card ROMs or the I/O space. It looks only at the request strobe, the read/write flag, the memory-versus-I/O qualifier, the address and a small shadow-control register. From these it produces one-hot target selects, a RAM-side address and a read-data return path. The address range from 640 KB up to 1 MB is a hole. Its lower 128 KB always belongs to the video buffer. Its upper 256 KB is split into eight 32 KB blocks that hold ROM code.

Firmware shadows each ROM block in two steps. It first enables RAM writes for the block and copies the ROM contents over, while reads still come from the ROM. It then turns on shadow reads and turns off writes, so the block reads from RAM and is write-protected. Two I/O ports hold the per-block bits. The hole RAM that sits behind the video range is never used, so it reappears directly above the top of installed memory. This happens only when installed memory is at most 8 MB. Decode is combinational. Only the shadow-control register is clocked.

Top module: `hole_decoder`

## Requirements
- R1: After reset both shadow-control bytes are 0x00. Every hole ROM read then selects a ROM, and every hole ROM write selects no target.
- R2: A memory access below 0xA0000, or from 0x100000 up to but not including the top of RAM (ramTopBlk × 64 KB, with ramTopBlk at least 16), asserts selRam with ramAddr equal to the address.
- R3: A memory read or write anywhere in 0xA0000–0xBFFFF asserts selVideo.
- R4: The range 0xC0000–0xFFFFF is split into eight 32 KB blocks, where block k starts at 0xC0000 + k × 0x8000. Blocks 0–5 are expansion ROM and blocks 6–7 are boot ROM. A read of block k while shadow-read bit k is clear asserts selOptRom for blocks 0–5 and selBootRom for blocks 6–7.
- R5: A read of block k while shadow-read bit k is set asserts selRam with ramAddr equal to the address.
- R6: A write to block k asserts selRam with ramAddr equal to the address when write-enable bit k is set. When that bit is clear, the write asserts no select and is silently dropped.
- R7: An access with isIo=1 decodes only addr[15:0]. It asserts selIo and never selRam, selVideo, selBootRom or selOptRom, except at the two control ports.
- R8: An I/O write to port 0x00E0 loads the shadow-read byte, and one to port 0x00E1 loads the write-enable byte, with bit k belonging to block k. The new value governs decode from the next clock. An I/O read of either port returns its byte on rdData. Neither port asserts any select.
- R9: When ramTopBlk ≤ 128 (8 MB), a memory access in [top, top + 0x20000) asserts selRam with ramAddr = 0xA0000 + (addr − top).
- R10: Memory accesses at or above top + 0x20000 select no target. When ramTopBlk > 128, memory accesses at or above top also select no target.
- R11: At most one select is asserted in any cycle, and none while req is low. A read that selects no target returns all ones (0xFF). Otherwise rdData carries the read data of the selected target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the shadow-control register |
| rstN | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access strobe, valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| isIo | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| addr | input | 24 | Physical address (I/O uses the low 16 bits) |
| wdata | input | 8 | Write data |
| ramTopBlk | input | 8 | Installed RAM size in 64 KB units |
| ramRdata | input | 8 | Read data from RAM |
| vidRdata | input | 8 | Read data from the video buffer |
| bootRdata | input | 8 | Read data from the boot ROM |
| optRdata | input | 8 | Read data from the expansion ROMs |
| ioRdata | input | 8 | Read data from the I/O space |
| selRam | output | 1 | RAM select |
| selVideo | output | 1 | Video buffer select |
| selBootRom | output | 1 | Boot ROM select |
| selOptRom | output | 1 | Expansion ROM select |
| selIo | output | 1 | I/O space select |
| ramAddr | output | 24 | Address presented to RAM |
| rdData | output | 8 | Read data returned to the CPU |

## Verification
The bench goes after the copy phase of shadowing, where writes must reach RAM while reads still hit ROM. A decoder that tied the read and write paths to one bit would send the copied bytes nowhere, or would read back uninitialised RAM. It also probes the block edges at 0xEFFFF/0xF0000 and 0xBFFFF/0xC0000, where an off-by-one block index would hand boot code to the expansion ROM. It checks the remap window at exactly 8 MB and at 8 MB + 64 KB, and the last byte of that window, where a wrong compare would alias the window, drop it, or translate it onto the wrong hole address. I/O cycles carrying hole-like addresses and reads of the control ports are included, since a decoder that looks at the qualifier late would select ROM or RAM on them.

// File: rtl/hole_pkg.sv
package hole_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic ram;
    logic video;
    logic bootRom;
    logic optRom;
    logic io;
    logic remap;   // RAM access goes through the above-top window
    logic portRd;  // read of a shadow-control port
  } hole_strobe_t;

endpackage

// File: rtl/hole_ctrl.sv
module hole_ctrl
  import hole_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 8,
  parameter int IO_W          = 16,
  parameter int BLK_SHIFT     = 15,
  parameter int VID_LO        = 'hA0000,
  parameter int ROM_LO        = 'hC0000,
  parameter int BOOT_LO       = 'hF0000,
  parameter int HOLE_HI       = 'h100000,
  parameter int REMAP_SIZE    = 'h20000,
  parameter int REMAP_MAX_BLK = 128,
  parameter int CTRL_PORT     = 'hE0,
  localparam int TOP_W        = ADDR_W - 16,
  localparam int NUM_BLK      = (HOLE_HI - ROM_LO) >> BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wr,
  input  logic              isIo,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TOP_W-1:0]  ramTopBlk,
  output hole_strobe_t      strb,
  output logic [DATA_W-1:0] portData
);

  localparam int BLK_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

  logic [NUM_BLK-1:0] shadowEn;
  logic [NUM_BLK-1:0] writeEn;
  logic [NUM_BLK-1:0] blkHit;
  logic [NUM_BLK-1:0] bootMask;
  logic [ADDR_W-1:0]  romOffset;
  logic [BLK_W-1:0]   blkIdx;
  logic               inRom;
  logic               blkShadow;
  logic               blkWrite;
  logic               blkBoot;
  logic [IO_W-1:0]    ioPort;
  logic               portHit0;
  logic               portHit1;
  logic [ADDR_W-1:0]  ramTop;
  logic [ADDR_W:0]    remapEnd;
  logic               remapOn;

  // ROM block index decode
  assign inRom     = (addr >= ADDR_W'(ROM_LO)) && (addr < ADDR_W'(HOLE_HI));
  assign romOffset = addr - ADDR_W'(ROM_LO);
  assign blkIdx    = romOffset[BLK_SHIFT +: BLK_W];

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    localparam bit IS_BOOT = (ROM_LO + (k << BLK_SHIFT)) >= BOOT_LO;
    assign blkHit[k]   = inRom && (blkIdx == BLK_W'(k));
    assign bootMask[k] = IS_BOOT;
  end

  assign blkShadow = |(blkHit & shadowEn);
  assign blkWrite  = |(blkHit & writeEn);
  assign blkBoot   = |(blkHit & bootMask);

  // Shadow-control ports
  assign ioPort   = addr[IO_W-1:0];
  assign portHit0 = (ioPort == IO_W'(CTRL_PORT));
  assign portHit1 = (ioPort == IO_W'(CTRL_PORT + 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowEn <= '0;
      writeEn  <= '0;
    end else if (req && wr && isIo) begin
      if (portHit0) shadowEn <= wdata[NUM_BLK-1:0];
      if (portHit1) writeEn  <= wdata[NUM_BLK-1:0];
    end
  end

  assign portData = portHit1 ? DATA_W'(writeEn) : DATA_W'(shadowEn);

  // Above-top remap window
  assign ramTop   = {ramTopBlk, 16'h0000};
  assign remapEnd = {1'b0, ramTop} + (ADDR_W+1)'(REMAP_SIZE);
  assign remapOn  = (int'(ramTopBlk) <= REMAP_MAX_BLK);

  always_comb begin
    strb = '0;
    if (req) begin
      if (isIo) begin
        if (portHit0 || portHit1) strb.portRd = !wr;
        else                      strb.io     = 1'b1;
      end else if (addr < ADDR_W'(VID_LO)) begin
        strb.ram = 1'b1;
      end else if (addr < ADDR_W'(ROM_LO)) begin
        strb.video = 1'b1;
      end else if (inRom) begin
        if (wr)             strb.ram     = blkWrite;
        else if (blkShadow) strb.ram     = 1'b1;
        else if (blkBoot)   strb.bootRom = 1'b1;
        else                strb.optRom  = 1'b1;
      end else if (addr < ramTop) begin
        strb.ram = 1'b1;
      end else if (remapOn && ({1'b0, addr} < remapEnd)) begin
        strb.ram   = 1'b1;
        strb.remap = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hole_data.sv
module hole_data
  import hole_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int REMAP_BASE = 'hA0000,
  localparam int TOP_W     = ADDR_W - 16
) (
  input  hole_strobe_t      strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TOP_W-1:0]  ramTopBlk,
  input  logic [DATA_W-1:0] portData,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] vidRdata,
  input  logic [DATA_W-1:0] bootRdata,
  input  logic [DATA_W-1:0] optRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              selRam,
  output logic              selVideo,
  output logic              selBootRom,
  output logic              selOptRom,
  output logic              selIo,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] ramTop;
  logic [ADDR_W-1:0] winOffset;

  assign ramTop    = {ramTopBlk, 16'h0000};
  assign winOffset = addr - ramTop;
  assign ramAddr   = strb.remap ? (ADDR_W'(REMAP_BASE) + winOffset) : addr;

  assign selRam     = strb.ram;
  assign selVideo   = strb.video;
  assign selBootRom = strb.bootRom;
  assign selOptRom  = strb.optRom;
  assign selIo      = strb.io;

  always_comb begin
    if (strb.ram)          rdData = ramRdata;
    else if (strb.video)   rdData = vidRdata;
    else if (strb.bootRom) rdData = bootRdata;
    else if (strb.optRom)  rdData = optRdata;
    else if (strb.io)      rdData = ioRdata;
    else if (strb.portRd)  rdData = portData;
    else                   rdData = '1;
  end

endmodule

// File: rtl/hole_decoder.sv
module hole_decoder
  import hole_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  localparam int TOP_W = ADDR_W - 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wr,
  input  logic              isIo,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TOP_W-1:0]  ramTopBlk,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] vidRdata,
  input  logic [DATA_W-1:0] bootRdata,
  input  logic [DATA_W-1:0] optRdata,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              selRam,
  output logic              selVideo,
  output logic              selBootRom,
  output logic              selOptRom,
  output logic              selIo,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] rdData
);

  hole_strobe_t      strb;
  logic [DATA_W-1:0] portData;

  hole_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .isIo(isIo),
    .addr(addr), .wdata(wdata), .ramTopBlk(ramTopBlk),
    .strb(strb), .portData(portData)
  );

  hole_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .strb(strb), .addr(addr), .ramTopBlk(ramTopBlk), .portData(portData),
    .ramRdata(ramRdata), .vidRdata(vidRdata), .bootRdata(bootRdata),
    .optRdata(optRdata), .ioRdata(ioRdata),
    .selRam(selRam), .selVideo(selVideo), .selBootRom(selBootRom),
    .selOptRom(selOptRom), .selIo(selIo),
    .ramAddr(ramAddr), .rdData(rdData)
  );

endmodule

// File: rtl/hole_decoder_chk.sv
module hole_decoder_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              wr,
  input logic              isIo,
  input logic [ADDR_W-1:0] addr,
  input logic              selRam,
  input logic              selVideo,
  input logic              selBootRom,
  input logic              selOptRom,
  input logic              selIo,
  input logic [DATA_W-1:0] rdData
);

  logic [4:0] selVec;
  logic       memReq;
  logic       inVid;
  logic       inRom;

  assign selVec = {selIo, selOptRom, selBootRom, selVideo, selRam};
  assign memReq = req && !isIo;
  assign inVid  = (addr >= ADDR_W'('hA0000)) && (addr < ADDR_W'('hC0000));
  assign inRom  = (addr >= ADDR_W'('hC0000)) && (addr < ADDR_W'('h100000));

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec)); // R11

  AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !req |-> (selVec == 5'b0)); // R11

  AST_UNCLAIMED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !wr && (selVec == 5'b0)) |-> (rdData == '1)); // R11

  AST_IO_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (req && isIo) |-> !(selRam || selVideo || selBootRom || selOptRom)); // R7

  AST_VIDEO_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && inVid) |-> selVideo); // R3

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && wr && inRom) |-> !(selBootRom || selOptRom)); // R6

  AST_ROM_READ_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !wr && inRom) |-> (selRam || selBootRom || selOptRom)); // R4

endmodule

bind hole_decoder hole_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .req(req), .wr(wr), .isIo(isIo), .addr(addr),
  .selRam(selRam), .selVideo(selVideo), .selBootRom(selBootRom),
  .selOptRom(selOptRom), .selIo(selIo), .rdData(rdData)
);

// File: tb/hole_decoder_tb_top.sv
module hole_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic        isIo = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  ramTopBlk = 8'd64;
  logic [7:0]  ramRdata = 8'h11;
  logic [7:0]  vidRdata = 8'h22;
  logic [7:0]  bootRdata = 8'h33;
  logic [7:0]  optRdata = 8'h44;
  logic [7:0]  ioRdata = 8'h55;
  logic        selRam, selVideo, selBootRom, selOptRom, selIo;
  logic [23:0] ramAddr;
  logic [7:0]  rdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model state for the two control bytes
  logic [7:0] mShadow = 8'h00;
  logic [7:0] mWrite = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  hole_decoder dut_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .isIo(isIo), .addr(addr),
    .wdata(wdata), .ramTopBlk(ramTopBlk), .ramRdata(ramRdata),
    .vidRdata(vidRdata), .bootRdata(bootRdata), .optRdata(optRdata),
    .ioRdata(ioRdata), .selRam(selRam), .selVideo(selVideo),
    .selBootRom(selBootRom), .selOptRom(selOptRom), .selIo(selIo),
    .ramAddr(ramAddr), .rdData(rdData)
  );

  // sel encoding: {io, opt, boot, video, ram}
  task automatic step(input string tag, input bit rq, input bit w, input bit io,
                      input int a, input int d);
    int  eSel, eAddr, eData, port, top, k;
    bit  portAcc;
    @(negedge clk);
    req = rq; wr = w; isIo = io; addr = 24'(a); wdata = 8'(d);
    eSel = 0; eAddr = a; eData = 255; portAcc = 0;
    top = int'(ramTopBlk) * 65536;
    if (rq) begin
      if (io) begin
        port = a % 65536;
        if (port == 'hE0 || port == 'hE1) begin
          portAcc = 1;
          eData = (port == 'hE0) ? int'(mShadow) : int'(mWrite);
        end else eSel = 16;
      end else if (a < 'hA0000) eSel = 1;
      else if (a < 'hC0000) eSel = 2;
      else if (a < 'h100000) begin
        k = (a - 'hC0000) / 32768;
        if (w) eSel = mWrite[k] ? 1 : 0;
        else if (mShadow[k]) eSel = 1;
        else eSel = (k >= 6) ? 4 : 8;
      end else if (a < top) eSel = 1;
      else if (ramTopBlk <= 8'd128 && a < top + 'h20000) begin
        eSel = 1; eAddr = 'hA0000 + (a - top);
      end
    end
    if (!portAcc) begin
      case (eSel)
        1: eData = 'h11;  2: eData = 'h22;  4: eData = 'h33;
        8: eData = 'h44; 16: eData = 'h55;
        default: eData = 255;
      endcase
    end
    #1;
    total++;
    if (int'({selIo, selOptRom, selBootRom, selVideo, selRam}) != eSel) begin
      bad++;
      $display("FAIL %s sel addr=%h io=%0d wr=%0d got=%b exp=%b", tag, a, io, w,
               {selIo, selOptRom, selBootRom, selVideo, selRam}, 5'(eSel));
    end
    if (eSel == 1) begin
      total++;
      if (int'(ramAddr) != eAddr) begin
        bad++;
        $display("FAIL %s ramAddr addr=%h got=%h exp=%h", tag, a, ramAddr, 24'(eAddr));
      end
    end
    if (rq && !w) begin
      total++;
      if (int'(rdData) != eData) begin
        bad++;
        $display("FAIL %s rdData addr=%h got=%h exp=%h", tag, a, rdData, 8'(eData));
      end
    end
    @(posedge clk);
    if (rq && w && io && (a % 65536) == 'hE0) mShadow = 8'(d);
    if (rq && w && io && (a % 65536) == 'hE1) mWrite = 8'(d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    step("R1", 1, 0, 1, 'hE0, 0);
    step("R1", 1, 0, 1, 'hE1, 0);
    step("R1", 1, 0, 0, 'hC0000, 0);
    step("R1", 1, 1, 0, 'hD0000, 8'h5A);
    // R2: direct RAM
    step("R2", 1, 0, 0, 'h00000, 0);
    step("R2", 1, 0, 0, 'h9FFFF, 0);
    step("R2", 1, 1, 0, 'h100000, 1);
    step("R2", 1, 0, 0, 'h3FFFFF, 0);
    // R3: video
    step("R3", 1, 0, 0, 'hA0000, 0);
    step("R3", 1, 1, 0, 'hB8000, 8'h41);
    step("R3", 1, 0, 0, 'hBFFFF, 0);
    // R4: ROM blocks and the boot/expansion edge
    step("R4", 1, 0, 0, 'hEFFFF, 0);
    step("R4", 1, 0, 0, 'hF0000, 0);
    step("R4", 1, 0, 0, 'hFFFFF, 0);
    // R7: I/O space
    step("R7", 1, 0, 1, 'h03F8, 0);
    step("R7", 1, 1, 1, 'h0080, 3);
    step("R7", 1, 0, 1, 'h0C00E0 + 'h100, 0);
    step("R7", 1, 0, 1, 'hF00DF, 0);
    // R8 / R6: copy phase, writes open for all blocks
    step("R8", 1, 1, 1, 'hE1, 8'hFF);
    step("R8", 1, 0, 1, 'hE1, 0);
    step("R6", 1, 1, 0, 'hC8000, 8'h99);
    step("R6", 1, 0, 0, 'hC8000, 0);
    // R8 / R5: shadow reads on blocks 0 and 7
    step("R8", 1, 1, 1, 'hE0, 8'h81);
    step("R8", 1, 0, 1, 'hE0, 0);
    step("R5", 1, 0, 0, 'hC0000, 0);
    step("R5", 1, 0, 0, 'hF8000, 0);
    step("R4", 1, 0, 0, 'hF0000, 0);
    step("R4", 1, 0, 0, 'hC8000, 0);
    // R6: lock writes, shadowed block still reads RAM
    step("R6", 1, 1, 1, 'hE1, 8'h00);
    step("R6", 1, 1, 0, 'hC0000, 8'h12);
    step("R6", 1, 1, 0, 'hF8000, 8'h13);
    step("R5", 1, 0, 0, 'hC7FFF, 0);
    // R9: remap window at 4 MB
    step("R9", 1, 0, 0, 'h400000, 0);
    step("R9", 1, 1, 0, 'h41FFFF, 7);
    step("R10", 1, 0, 0, 'h420000, 0);
    // R9: exactly 8 MB installed
    ramTopBlk = 8'd128;
    step("R9", 1, 0, 0, 'h7FFFFF, 0);
    step("R9", 1, 0, 0, 'h800000, 0);
    step("R9", 1, 0, 0, 'h81FFFF, 0);
    // R10: above 8 MB, no remap
    ramTopBlk = 8'd129;
    step("R10", 1, 0, 0, 'h80FFFF, 0);
    step("R10", 1, 0, 0, 'h810000, 0);
    ramTopBlk = 8'd200;
    step("R10", 1, 1, 0, 'hC80000, 1);
    step("R10", 1, 0, 0, 'hFFFFFF, 0);
    // R11: idle bus
    step("R11", 0, 0, 0, 'h00000, 0);
    step("R11", 0, 0, 1, 'h03F8, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule